// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer on a small register bus with an address, a write enable, write data and combinational read data. A down-counter of 16 bits counts ticks that come from two division stages in series: an 8-bit programmable prescaler, then a fixed divider picked from four powers of two between 16 and 128. Software keeps the system alive by writing a fresh value into the live count before it runs out.

When a tick finds the counter at zero, the counter takes the reload value again. On that expiry the block can raise a one-cycle interrupt pulse, a sticky request for a system reset, or both. Each action has its own enable bit. A run bit gates all counting. The prescaler and divider state is cleared while the run bit is low, so each enable begins a full tick period. The control register, the reload value and the live count are three separate registers, and each can be written directly.

Top module: `prescaled_watchdog`

## Requirements
- R1: After a synchronous reset the control register reads 0 (stopped, both actions off), the reload and count registers read 0x8000, and `irq_o` and `rst_req_o` are low.
- R2: Address 0 is control, with bit 0 as run, bit 1 as interrupt enable, bit 2 as reset enable, bits 4:3 as divider select and bits 15:8 as prescale value. Bits 7:5 read 0. Address 1 is the reload value and address 2 is the live count. Address 3 reads 0, and a write to it changes no register.
- R3: One tick period is (prescale+1)·D clock cycles, where D is 16, 32, 64 or 128 for divider select 0, 1, 2 or 3. The counter decrements once per tick. An expiry happens on the tick that finds the counter at 0, so a count of N with the run bit set expires (N+1) periods after the enable write.
- R4: The prescaler and divider restart from zero while run is low, so the first tick after enabling comes one full period after the enabling write.
- R5: With run low the live count holds its value, except when software writes the count register.
- R6: On expiry the live count takes the value of the reload register.
- R7: With interrupt enable set, an expiry drives `irq_o` high for exactly one cycle, starting at the clock edge where the counter reloads.
- R8: With reset enable set, an expiry sets `rst_req_o`. It stays high until the block is reset, even if the control register is later cleared.
- R9: The two actions are independent. An expiry raises only the outputs whose enable bit is set, and when both are set both rise at the same edge.
- R10: A write to the count register replaces the live value at once and restarts the countdown from it. If a tick falls on the same cycle, the write wins.
- R11: Writing control with run and reset enable both clear stops the watchdog. The count freezes and no further interrupt or reset request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | One-cycle interrupt pulse on expiry |
| rst_req_o | output | 1 | Sticky system reset request |

## Verification
The interrupt pulse and the reset request can both come from one expiry in the same cycle. The bench resets the block first, so the sticky request starts low. It then arms both enables with a short count and a period of 16 cycles, waits for the first edge where either output is high, and requires both to be high at that edge. Separate runs arm each enable on its own and check that the other output stays low, which confirms the two actions are independent.

// File: rtl/pw_pkg.sv
// Package: shared widths, register addresses and control layout for the watchdog.
// Assumes a 16-bit bus; control fields are placed at fixed bit positions.
package pw_pkg;
    localparam int DATA_W = 16;
    localparam int PRE_W  = 8;
    localparam int SEL_W  = 2;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_RELOAD = 2'd1,
        REG_COUNT  = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [SEL_W-1:0] div_sel;
        logic             rst_en;
        logic             irq_en;
        logic             run;
    } ctrl_t;

    // Pack the control struct into its bus word (bits 7:5 read as zero)
    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        return {c.pre, 3'b000, c.div_sel, c.rst_en, c.irq_en, c.run};
    endfunction

    // Unpack a bus word into the control struct
    function automatic ctrl_t word_to_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.pre     = w[15:8];
        c.div_sel = w[4:3];
        c.rst_en  = w[2];
        c.irq_en  = w[1];
        c.run     = w[0];
        return c;
    endfunction
endpackage

// File: rtl/pw_regs.sv
// Module: register decode and storage for control and reload, read mux for all three.
// Assumes single-cycle writes; the live count is stored in pw_counter, so this
// module only forwards a write strobe and data for it.
module pw_regs
    import pw_pkg::*;
#(
    parameter logic [DATA_W-1:0] RESET_COUNT = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] cnt_i,
    output logic [DATA_W-1:0] bus_rdata,
    output ctrl_t             ctrl_o,
    output logic [DATA_W-1:0] reload_o,
    output logic              cnt_wr_o,
    output logic [DATA_W-1:0] cnt_wdata_o
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(bus_addr);

    // Store control and reload on their write strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_o   <= '0;
            reload_o <= RESET_COUNT;
        end else if (bus_we) begin
            if (sel == REG_CTRL)   ctrl_o   <= word_to_ctrl(bus_wdata);
            if (sel == REG_RELOAD) reload_o <= bus_wdata;
        end
    end

    assign cnt_wr_o    = bus_we && (sel == REG_COUNT);
    assign cnt_wdata_o = bus_wdata;

    // Read mux: stored values for control and reload, live value for count
    always_comb begin
        unique case (sel)
            REG_CTRL:   bus_rdata = ctrl_to_word(ctrl_o);
            REG_RELOAD: bus_rdata = reload_o;
            REG_COUNT:  bus_rdata = cnt_i;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pw_tickgen.sv
// Module: two-stage divider, a programmable prescaler followed by a selectable
// power-of-two divider of 2**BASE_LOG2 up to 2**(BASE_LOG2 + 2**SEL_W - 1).
// Assumes settings are changed only while stopped; both stages clear when run is low.
module pw_tickgen #(
    parameter int PRE_W     = 8,
    parameter int SEL_W     = 2,
    parameter int BASE_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] pre,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick_o
);
    localparam int NSEL  = 1 << SEL_W;
    localparam int DIV_W = BASE_LOG2 + NSEL - 1;

    logic [PRE_W-1:0] pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_lim [NSEL];
    logic             pre_last, div_last;

    // One terminal value per divider select
    for (genvar g = 0; g < NSEL; g++) begin : g_lim
        assign div_lim[g] = DIV_W'((2 ** (BASE_LOG2 + g)) - 1);
    end

    assign pre_last = (pre_cnt == pre);
    assign div_last = (div_cnt == div_lim[div_sel]);
    assign tick_o   = run && pre_last && div_last;

    // Advance prescaler every cycle, divider on each prescaler wrap
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (pre_last) begin
            pre_cnt <= '0;
            div_cnt <= div_last ? '0 : div_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pw_counter.sv
// Module: live down-counter with reload on expiry and the two expiry actions.
// Assumes tick is a single-cycle strobe; a software load overrides a coincident tick.
module pw_counter #(
    parameter int               CNT_W       = 16,
    parameter logic [CNT_W-1:0] RESET_COUNT = 16'h8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload,
    input  logic             irq_en,
    input  logic             rst_en,
    output logic [CNT_W-1:0] cnt_o,
    output logic             irq_o,
    output logic             rst_req_o
);
    logic expire;
    assign expire = tick && !load_en && (cnt_o == '0);

    // Count, reload and raise the enabled expiry actions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o     <= RESET_COUNT;
            irq_o     <= 1'b0;
            rst_req_o <= 1'b0;
        end else begin
            irq_o <= expire && irq_en;
            if (expire && rst_en) rst_req_o <= 1'b1;
            if (load_en)          cnt_o <= load_val;
            else if (expire)      cnt_o <= reload;
            else if (tick)        cnt_o <= cnt_o - 1'b1;
        end
    end
endmodule

// File: rtl/prescaled_watchdog.sv
// Module: top of the watchdog; joins register file, tick generator and counter.
// Assumes one clock domain and a synchronous active-low reset.
module prescaled_watchdog
    import pw_pkg::*;
#(
    parameter int                BASE_LOG2   = 4,
    parameter logic [DATA_W-1:0] RESET_COUNT = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              rst_req_o
);
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] reload_q, cnt_q, cnt_wdata;
    logic              cnt_wr, tick;

    pw_regs #(.RESET_COUNT(RESET_COUNT)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .cnt_i(cnt_q), .bus_rdata(bus_rdata),
        .ctrl_o(ctrl_q), .reload_o(reload_q), .cnt_wr_o(cnt_wr),
        .cnt_wdata_o(cnt_wdata)
    );

    pw_tickgen #(.PRE_W(PRE_W), .SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2)) tick_i (
        .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .pre(ctrl_q.pre),
        .div_sel(ctrl_q.div_sel), .tick_o(tick)
    );

    pw_counter #(.CNT_W(DATA_W), .RESET_COUNT(RESET_COUNT)) cnt_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load_en(cnt_wr),
        .load_val(cnt_wdata), .reload(reload_q), .irq_en(ctrl_q.irq_en),
        .rst_en(ctrl_q.rst_en), .cnt_o(cnt_q), .irq_o(irq_o),
        .rst_req_o(rst_req_o)
    );
endmodule

// File: rtl/pw_checker.sv
// Module: temporal properties of the watchdog, bound onto the top module.
// Assumes it observes bus inputs, stored control bits, reload, live count and outputs.
module pw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  bus_addr,
    input logic        bus_we,
    input logic        run,
    input logic        irq_en,
    input logic        rst_en,
    input logic [15:0] count,
    input logic [15:0] reload,
    input logic        irq_o,
    input logic        rst_req_o
);
    // R5: stopped and not written means the count keeps its value
    assert_halt_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !(bus_we && bus_addr == 2'd2)) |=> $stable(count));

    // R6: the cycle the interrupt shows, the count holds the reload value used
    assert_reload_on_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (count == $past(reload)));

    // R7: interrupt is a single-cycle pulse
    assert_irq_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R8: reset request stays once raised
    assert_rst_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> rst_req_o);

    // R9: interrupt only when its enable was set
    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(irq_en));

    // R9: reset request only rises when its enable was set
    assert_rst_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> $past(rst_en));
endmodule

bind prescaled_watchdog pw_checker chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .run(ctrl_q.run), .irq_en(ctrl_q.irq_en), .rst_en(ctrl_q.rst_en),
    .count(cnt_q), .reload(reload_q), .irq_o(irq_o), .rst_req_o(rst_req_o)
);

// File: tb/prescaled_watchdog_tb_top.sv
module prescaled_watchdog_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        irq_o, rst_req_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    prescaled_watchdog dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
        .rst_req_o(rst_req_o)
    );

    typedef struct packed {
        logic [7:0]  pre;
        logic [1:0]  sel;
        logic [15:0] start;
        logic [15:0] reload;
        logic [15:0] cycles;
    } vec_t;

    // Expected cycles = (start+1) * (pre+1) * (16 << sel)
    localparam vec_t VECS [5] = '{
        '{8'd0,   2'd0, 16'd3, 16'h0005, 16'd64},
        '{8'd2,   2'd1, 16'd1, 16'h00A0, 16'd192},
        '{8'd1,   2'd2, 16'd0, 16'h1234, 16'd128},
        '{8'd0,   2'd3, 16'd2, 16'hFFFF, 16'd384},
        '{8'd255, 2'd0, 16'd0, 16'h0001, 16'd4096}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        step();
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; step(); step(); rst_n = 1'b1;
    endtask

    // Wait for irq or reset request; return cycles counted after the call
    task automatic wait_event(input int limit, output int cyc);
        cyc = 0;
        do begin
            step(); cyc++;
        end while (!irq_o && !rst_req_o && cyc < limit);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, held;
        int cyc;
        do_reset();

        // R1: reset state
        rd(2'd0, v); check(v == 16'h0000, "R1 ctrl", v, 0);
        rd(2'd1, v); check(v == 16'h8000, "R1 reload", v, 16'h8000);
        rd(2'd2, v); check(v == 16'h8000, "R1 count", v, 16'h8000);
        check(!irq_o && !rst_req_o, "R1 outputs", {irq_o, rst_req_o}, 0);

        // R2: control readback with reserved bits dropped, unused address
        wr(2'd0, 16'hA7F8);
        rd(2'd0, v); check(v == 16'hA718, "R2 ctrl readback", v, 16'hA718);
        wr(2'd0, 16'h0000);
        wr(2'd3, 16'h1234);
        rd(2'd3, v); check(v == 16'h0000, "R2 unused reads 0", v, 0);
        rd(2'd1, v); check(v == 16'h8000, "R2 unused write ignored", v, 16'h8000);

        // R5: stopped counter holds the written count
        wr(2'd2, 16'h0042);
        repeat (300) step();
        rd(2'd2, v); check(v == 16'h0042, "R5 halted count", v, 16'h0042);

        // R3 R4 R6 R7: table of period/reload vectors
        foreach (VECS[i]) begin
            wr(2'd0, 16'h0000);
            wr(2'd1, VECS[i].reload);
            wr(2'd2, VECS[i].start);
            wr(2'd0, {VECS[i].pre, 3'b000, VECS[i].sel, 3'b011});
            wait_event(int'(VECS[i].cycles) + 20, cyc);
            check(cyc == int'(VECS[i].cycles) && irq_o, "R3 R4 expiry cycles", cyc, int'(VECS[i].cycles));
            rd(2'd2, v); check(v == VECS[i].reload, "R6 reload on expiry", v, VECS[i].reload);
            step();
            check(!irq_o, "R7 irq one cycle", irq_o, 0);
        end
        wr(2'd0, 16'h0000);

        // R10: servicing the count postpones expiry
        wr(2'd1, 16'h0003);
        wr(2'd2, 16'h0001);
        wr(2'd0, 16'h0003);
        repeat (20) step();
        wr(2'd2, 16'h0007);
        rd(2'd2, v); check(v == 16'h0007, "R10 count write", v, 7);
        wait_event(30, cyc);
        check(!irq_o, "R10 no expiry after service", irq_o, 0);
        wr(2'd0, 16'h0000);

        // R8 R9: reset-only expiry, then sticky after stop
        wr(2'd2, 16'h0000);
        wr(2'd0, 16'h0005);
        wait_event(40, cyc);
        check(rst_req_o && cyc == 16, "R8 reset request timing", cyc, 16);
        check(!irq_o, "R9 irq off when disabled", irq_o, 0);
        wr(2'd0, 16'h0000);
        repeat (40) step();
        check(rst_req_o, "R8 sticky request", rst_req_o, 1);

        // R9: both actions in the same cycle
        do_reset();
        check(!rst_req_o, "R8 cleared by reset", rst_req_o, 0);
        wr(2'd2, 16'h0000);
        wr(2'd0, 16'h0007);
        wait_event(40, cyc);
        check(irq_o && rst_req_o && cyc == 16, "R9 both same edge", {irq_o, rst_req_o}, 3);

        // R11: clearing run and reset enable freezes everything
        do_reset();
        wr(2'd1, 16'h0000);
        wr(2'd2, 16'h0002);
        wr(2'd0, 16'h0007);
        repeat (20) step();
        wr(2'd0, 16'h0002);
        rd(2'd2, held);
        cyc = 0;
        repeat (200) begin
            step();
            if (irq_o || rst_req_o) cyc++;
        end
        rd(2'd2, v); check(v == held, "R11 count frozen", v, held);
        check(cyc == 0, "R11 no outputs after stop", cyc, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule